// File: doc/BRIEF.md
# Pulse Add/Delete Clock Divider

This block is the frequency-correcting stage of an all-digital phase-locked loop. It runs from an increment/decrement rate strobe (`id_tick`) qualified on the fabric clock `id_clk`. With no corrections it emits one output pulse for every second strobe, so its output runs at half the strobe rate. A carry request from the loop filter inserts one extra output pulse, which advances the phase. A borrow request swallows one output pulse, which retards it.

Carry and borrow are produced in a separate filter clock domain (`k_clk`). Each request is held as a toggle flag, passed into the `id_clk` domain through a multi-flop synchronizer, and acknowledged back the same way. At most one carry and one borrow can be outstanding. An external divide-by-N counter normally follows the output, which sets the loop centre frequency to the strobe rate divided by 2N. When carries and borrows arrive at equal rates the corrections cancel, and the output averages half the strobe rate.

Top module: `idpulse_divider`

## Requirements
- R1: While `id_rst` and `k_rst` are asserted, and after they are released together, `id_out` is low, the strobe parity is even and no carry or borrow is outstanding. A request raised before the reset has no effect after it.
- R2: `id_out` is high for exactly one `id_clk` cycle, in the cycle after a cycle in which `id_tick` was high, and at no other time. Strobes must be at least two cycles apart.
- R3: With nothing outstanding, strobes alternate between odd and even, starting with odd after reset. An odd strobe gives no pulse and an even strobe gives a pulse, so 2M strobes give exactly M pulses.
- R4: An outstanding carry is consumed at the next odd strobe, which then also gives a pulse. Pulses therefore appear on two consecutive strobes, and the count over the window rises by one.
- R5: An outstanding borrow is consumed at the next even strobe, whose pulse is suppressed. The count over the window falls by one.
- R6: A carry (or borrow) pulse on `carry_in` (`borrow_in`) that arrives while an earlier one of the same kind is still unacknowledged is dropped.
- R7: If a carry and a borrow are both outstanding at a strobe, both are consumed at that strobe and the output follows R3.
- R8: Requests cross into the `id_clk` domain through `SYNC_STAGES` flops. Without strobes an outstanding request is held indefinitely and produces no output.
- R9: Over a window with equal numbers of carries and borrows, the pulse count equals half the number of strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k_clk | input | 1 | Filter-side clock |
| k_rst | input | 1 | Synchronous active-high reset, filter side |
| carry_in | input | 1 | One-cycle carry request, `k_clk` domain |
| borrow_in | input | 1 | One-cycle borrow request, `k_clk` domain |
| id_clk | input | 1 | Fabric clock of the divider |
| id_rst | input | 1 | Synchronous active-high reset, divider side |
| id_tick | input | 1 | Increment/decrement rate strobe, one cycle wide |
| id_out | output | 1 | Registered output pulse stream |

## Verification
On every cycle the assertions check the pulse-after-strobe timing, the alternation of strobe parity, the choice of strobe at which a carry or borrow is consumed, the clearing of both requests when they cancel, and that the state holds still between strobes. Dropping of surplus requests, the survival of a request through a long stall, the clearing of a stale request by reset, and the pulse counts over whole windows (including the balanced carry/borrow case) involve both clock domains and long histories. Only the bench's scenarios show those.

// File: rtl/idpd_pkg.sv
package idpd_pkg;
  // correction chosen at a strobe
  typedef enum logic [1:0] {
    CORR_NONE   = 2'd0,
    CORR_ADD    = 2'd1,
    CORR_DEL    = 2'd2,
    CORR_CANCEL = 2'd3
  } corr_e;

  localparam int CH_ADD = 0;
  localparam int CH_DEL = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/idpd_evt_xfer.sv
// Toggle-flag request crossing with acknowledge back to the source domain.
module idpd_evt_xfer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic k_clk,
  input  logic k_rst,
  input  logic ev_in,
  input  logic id_clk,
  input  logic id_rst,
  input  logic take,
  output logic pending
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                   req_t;
  logic                   ack_t;
  logic [SYNC_STAGES-1:0] ack_sh;
  logic [SYNC_STAGES-1:0] req_sh;
  logic                   k_busy;

  assign k_busy = req_t ^ ack_sh[LAST];

  // source side: raise a new request only once the last one is acknowledged
  always_ff @(posedge k_clk) begin
    if (k_rst) begin
      req_t  <= 1'b0;
      ack_sh <= '0;
    end else begin
      ack_sh <= {ack_sh[LAST-1:0], ack_t};
      if (ev_in && !k_busy) req_t <= ~req_t;
    end
  end

  // divider side: a request is outstanding while the flags differ
  always_ff @(posedge id_clk) begin
    if (id_rst) begin
      req_sh <= '0;
      ack_t  <= 1'b0;
    end else begin
      req_sh <= {req_sh[LAST-1:0], req_t};
      if (take) ack_t <= req_sh[LAST];
    end
  end

  assign pending = req_sh[LAST] ^ ack_t;
endmodule

// File: rtl/idpd_core.sv
// Strobe-driven divide-by-two with pulse insertion and removal.
module idpd_core
  import idpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic add_pend,
  input  logic del_pend,
  output logic add_take,
  output logic del_take,
  output logic phase,
  output logic pulse_out
);
  corr_e corr;
  logic  fire;
  logic  phase_q;
  logic  out_q;

  always_comb begin
    corr = CORR_NONE;
    if (add_pend && del_pend)      corr = CORR_CANCEL;
    else if (add_pend && !phase_q) corr = CORR_ADD;
    else if (del_pend && phase_q)  corr = CORR_DEL;
  end

  always_comb begin
    case (corr)
      CORR_ADD: fire = 1'b1;
      CORR_DEL: fire = 1'b0;
      default:  fire = phase_q;
    endcase
  end

  assign add_take = tick && (corr == CORR_ADD || corr == CORR_CANCEL);
  assign del_take = tick && (corr == CORR_DEL || corr == CORR_CANCEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      out_q <= tick & fire;
      if (tick) phase_q <= ~phase_q;
    end
  end

  assign phase     = phase_q;
  assign pulse_out = out_q;
endmodule

// File: rtl/idpulse_divider.sv
module idpulse_divider
  import idpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic k_clk,
  input  logic k_rst,
  input  logic carry_in,
  input  logic borrow_in,
  input  logic id_clk,
  input  logic id_rst,
  input  logic id_tick,
  output logic id_out
);
  logic [NUM_CH-1:0] ev_vec;
  logic [NUM_CH-1:0] pend_vec;
  logic [NUM_CH-1:0] take_vec;
  logic              add_pend;
  logic              del_pend;
  logic              phase;

  assign ev_vec[CH_ADD] = carry_in;
  assign ev_vec[CH_DEL] = borrow_in;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_xfer
    idpd_evt_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .k_clk   (k_clk),
      .k_rst   (k_rst),
      .ev_in   (ev_vec[g]),
      .id_clk  (id_clk),
      .id_rst  (id_rst),
      .take    (take_vec[g]),
      .pending (pend_vec[g])
    );
  end

  assign add_pend = pend_vec[CH_ADD];
  assign del_pend = pend_vec[CH_DEL];

  idpd_core u_core (
    .clk       (id_clk),
    .rst       (id_rst),
    .tick      (id_tick),
    .add_pend  (add_pend),
    .del_pend  (del_pend),
    .add_take  (take_vec[CH_ADD]),
    .del_take  (take_vec[CH_DEL]),
    .phase     (phase),
    .pulse_out (id_out)
  );
endmodule

// File: rtl/idpd_checker.sv
module idpd_checker (
  input logic id_clk,
  input logic id_rst,
  input logic id_tick,
  input logic id_out,
  input logic add_pend,
  input logic del_pend,
  input logic phase
);
  assert_out_after_tick_R2: assert property (@(posedge id_clk) disable iff (id_rst)
    id_out |-> $past(id_tick));

  assert_idle_hold_R2: assert property (@(posedge id_clk) disable iff (id_rst)
    !id_tick |=> (!id_out && $stable(phase)));

  assert_parity_flip_R3: assert property (@(posedge id_clk) disable iff (id_rst)
    id_tick |=> (phase != $past(phase)));

  assert_odd_quiet_R3: assert property (@(posedge id_clk) disable iff (id_rst)
    (id_tick && !add_pend && !del_pend && !phase) |=> !id_out);

  assert_even_pulse_R3: assert property (@(posedge id_clk) disable iff (id_rst)
    (id_tick && !add_pend && !del_pend && phase) |=> id_out);

  assert_add_inserts_R4: assert property (@(posedge id_clk) disable iff (id_rst)
    (id_tick && add_pend && !del_pend && !phase) |=> (id_out && !add_pend));

  assert_del_swallows_R5: assert property (@(posedge id_clk) disable iff (id_rst)
    (id_tick && del_pend && !add_pend && phase) |=> (!id_out && !del_pend));

  assert_cancel_clears_R7: assert property (@(posedge id_clk) disable iff (id_rst)
    (id_tick && add_pend && del_pend) |=> (!add_pend && !del_pend));

  assert_held_no_tick_R8: assert property (@(posedge id_clk) disable iff (id_rst)
    (!id_tick && add_pend) |=> add_pend);
endmodule

bind idpulse_divider idpd_checker u_idpd_checker (
  .id_clk   (id_clk),
  .id_rst   (id_rst),
  .id_tick  (id_tick),
  .id_out   (id_out),
  .add_pend (add_pend),
  .del_pend (del_pend),
  .phase    (phase)
);

// File: tb/idpulse_divider_bench.sv
`timescale 1ns/100ps
module idpulse_divider_bench;
  logic k_clk = 1'b0;
  logic id_clk = 1'b0;
  logic k_rst = 1'b1;
  logic id_rst = 1'b1;
  logic carry_in = 1'b0;
  logic borrow_in = 1'b0;
  logic id_tick = 1'b0;
  logic id_out;

  always #2.0 id_clk = ~id_clk;   // 250 MHz
  always #3.5 k_clk = ~k_clk;

  idpulse_divider u_idpulse_divider (
    .k_clk(k_clk), .k_rst(k_rst), .carry_in(carry_in), .borrow_in(borrow_in),
    .id_clk(id_clk), .id_rst(id_rst), .id_tick(id_tick), .id_out(id_out)
  );

  typedef struct {
    int    exp_cnt;
    bit    want_pair;
    string tag;
  } exp_t;

  exp_t q[$];
  event win_end;
  int   n_checks = 0;
  int   n_err = 0;
  int   pulse_cnt = 0;
  int   stray = 0;
  bit   pair_seen = 0;
  bit   last_tick = 0;
  bit   prev_tick_pulse = 0;

  // monitor: sample away from the active edge
  always @(negedge id_clk) begin
    if (id_out) pulse_cnt++;
    if (id_out && !last_tick) stray++;
    if (last_tick) begin
      if (id_out && prev_tick_pulse) pair_seen = 1;
      prev_tick_pulse = id_out;
    end
    last_tick = id_tick;
  end

  // scoreboard comparison
  initial begin
    forever begin
      @(win_end);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (pulse_cnt != e.exp_cnt) begin
          n_err++;
          $display("FAIL %s: pulse count actual=%0d expected=%0d", e.tag, pulse_cnt, e.exp_cnt);
        end
        if (e.want_pair) begin
          n_checks++;
          if (!pair_seen) begin
            n_err++;
            $display("FAIL %s: consecutive-strobe pulses actual=0 expected=1", e.tag);
          end
        end
      end
    end
  end

  task automatic open_window(int exp_cnt, bit want_pair, string tag);
    exp_t e;
    e.exp_cnt = exp_cnt; e.want_pair = want_pair; e.tag = tag;
    q.push_back(e);
    pulse_cnt = 0;
    pair_seen = 0;
    prev_tick_pulse = 0;
  endtask

  task automatic close_window();
    repeat (4) @(posedge id_clk);
    #1;
    ->win_end;
    @(negedge id_clk);
  endtask

  task automatic run_ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge id_clk); #1 id_tick = 1'b1;
      @(posedge id_clk); #1 id_tick = 1'b0;
      repeat (gap - 2) @(posedge id_clk);
    end
  endtask

  task automatic k_event(bit c, bit b);
    @(posedge k_clk); #1; carry_in = c; borrow_in = b;
    @(posedge k_clk); #1; carry_in = 1'b0; borrow_in = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(posedge k_clk);
    repeat (6) @(posedge id_clk);
  endtask

  task automatic do_reset();
    #1; k_rst = 1'b1; id_rst = 1'b1;
    repeat (5) @(posedge k_clk);
    @(negedge id_clk);
    n_checks++;
    if (id_out !== 1'b0) begin
      n_err++;
      $display("FAIL R1: id_out in reset actual=%b expected=0", id_out);
    end
    @(posedge id_clk); #1;
    k_rst = 1'b0; id_rst = 1'b0;
    repeat (3) @(posedge id_clk);
  endtask

  initial begin
    fork
      begin
        do_reset();

        // R3: plain halving, two strobe spacings
        open_window(8, 0, "R3 gap2"); run_ticks(16, 2); close_window();
        open_window(6, 0, "R3 gap3"); run_ticks(12, 3); close_window();

        // R4: one carry adds a pulse on two consecutive strobes
        k_event(1, 0); settle();
        open_window(5, 1, "R4 carry"); run_ticks(8, 2); close_window();

        // R5: one borrow removes a pulse
        k_event(0, 1); settle();
        open_window(3, 0, "R5 borrow"); run_ticks(8, 2); close_window();

        // R6: repeated carries before acknowledge collapse to one
        k_event(1, 0); repeat (3) @(posedge k_clk);
        k_event(1, 0); repeat (3) @(posedge k_clk);
        k_event(1, 0); settle();
        // R8: held through a long stall with no output
        open_window(0, 0, "R8 stall"); repeat (60) @(posedge id_clk); close_window();
        open_window(5, 0, "R6 drop"); run_ticks(8, 2); close_window();

        // R7: both outstanding cancel
        k_event(1, 1); settle();
        open_window(4, 0, "R7 cancel"); run_ticks(8, 2); close_window();

        // R9: balanced carries and borrows
        open_window(8, 0, "R9 balance");
        for (int i = 0; i < 2; i++) begin
          k_event(1, 0); settle(); run_ticks(4, 2);
          k_event(0, 1); settle(); run_ticks(4, 3);
        end
        close_window();

        // R1: stale request cleared by reset
        k_event(1, 0); settle();
        do_reset();
        open_window(4, 0, "R1 reset clears"); run_ticks(8, 2); close_window();

        // R2: no pulse ever outside the cycle after a strobe
        n_checks++;
        if (stray != 0) begin
          n_err++;
          $display("FAIL R2: stray pulses actual=%0d expected=0", stray);
        end
      end
      begin
        repeat (100000) @(posedge id_clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: run hung actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule